// File: doc/BRIEF.md
# CPU Variant Detection Sequencer

This block sits on the bus of an 8-bit microprocessor socket whose exact part is unknown. It owns the processor's clock enable and reset. It answers every read with a byte it makes up itself, and from the address trace it decides which of four variants is fitted:

- an NMOS part;
- a CMOS part that has the bit set/clear instructions;
- a CMOS part without them;
- a 16-bit-capable CMOS part.

One `clk` cycle stands for one processor bus cycle.

After `start`, the sequencer holds the processor in reset for a few clocked cycles and then releases it. When the processor fetches its reset vector, the sequencer returns an entry address that it controls. At that address it serves an indirect jump through pointer `$FFFF`. The address the processor then uses to fetch the pointer's high byte tells the variants apart:

- `$FF00` means a part with the page-wrap bug.
- `$0000` in the very next cycle means the 16-bit-capable part.
- `$0000` one or more cycles later means an 8-bit CMOS part.

The jump target holds a set-bit-0 opcode on a zero-page byte. A zero-page read of that byte within a short window shows that the bit instructions exist. When the sequencer finishes, it pulses `done`, stops the clock and puts the processor back into reset. If an expected address never comes, it raises `err`.

Top module: `cpu_variant_detect`

## Requirements
- R1: After reset, `cpu_clk_en` is 0, `cpu_rst_n` is 0, and `done`, `err` and `variant` are all 0.
- R2: After a `start` pulse, `cpu_clk_en` is 1 and `cpu_rst_n` is 0 for exactly RST_CYC cycles (default 4). Then `cpu_rst_n` rises while the clock stays enabled.
- R3: `cpu_data_out` gives the following bytes:

  | Read address | Byte |
  |---|---|
  | `$FFFC` | `$00` |
  | `$FFFD` | `$10` (entry address `$1000`) |
  | `$1000` | `$6C` |
  | `$1001` | `$FF` |
  | `$1002` | `$FF` |
  | `$FFFF` | `$00` |
  | `$FF00` | `$20` |
  | `$0000` | `$20` (target `$2000`) |
  | `$2000` | `$87` |
  | `$2001` | `$40` |
  | any other address | `$EA` |

- R4: When the read after the `$FFFF` fetch is at `$FF00`, the result is `variant` = 0 (NMOS).
- R5: When a read of `$0000` comes in the cycle directly after the `$FFFF` read, the result is `variant` = 3 (16-bit-capable part).
- R6: When `$0000` is read one or more cycles later, the block waits for the opcode fetch at `$2000`. A read of `$0040` within the 6 cycles after that fetch gives `variant` = 1 (bit instructions present). This includes a read in the sixth cycle.
- R7: When no read of `$0040` happens in those 6 cycles, the result is `variant` = 2. Writes to `$0040` do not count.
- R8: `done` is a one-cycle pulse. In the cycle where it is high, `cpu_rst_n` is already 0 again and `cpu_clk_en` is 0.
- R9: When the awaited address does not appear within 16 cycles of any waiting step, `err` is set and `done` pulses. `variant` keeps its previous value.
- R10: A new `start` clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one tick per processor bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a detection run (taken only when idle) |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw | input | 1 | Processor read (1) / write (0) |
| cpu_data_out | output | 8 | Synthesized byte for the current read address |
| cpu_clk_en | output | 1 | Enables clock pulses to the processor |
| cpu_rst_n | output | 1 | Active-low reset to the processor |
| variant | output | 2 | Detected variant code |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Detection timed out |

## Verification
The bench aims at the cycle gap between the `$FFFF` and `$0000` fetches, where a gap of one cycle and a gap of two must give different codes. A sequencer that counted from the wrong cycle would report the 16-bit part as an 8-bit CMOS part, or the other way round.

The probe window is tested at both edges:

- a zero-page read in its last cycle must still count;
- a zero-page write must not count.

An off-by-one window, or a decoder that ignores the read/write line, would misreport the two 8-bit CMOS parts.

Timeouts are forced in two different waiting steps. This shows that the error path keeps the previous variant code and that the next start clears the error.

// File: rtl/cpu_probe_pkg.sv
package cpu_probe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_VECTOR,
        ST_POINTER,
        ST_HIGH,
        ST_FETCH,
        ST_PROBE
    } probe_state_e;

    localparam logic [1:0] VAR_NMOS       = 2'd0;
    localparam logic [1:0] VAR_CMOS_BIT   = 2'd1;
    localparam logic [1:0] VAR_CMOS_NOBIT = 2'd2;
    localparam logic [1:0] VAR_WIDE       = 2'd3;

    localparam logic [7:0] OP_JMP_IND = 8'h6C;
    localparam logic [7:0] OP_SET_B0  = 8'h87;
    localparam logic [7:0] OP_FILL    = 8'hEA;

    localparam logic [15:0] ADR_VEC_LO  = 16'hFFFC;
    localparam logic [15:0] ADR_VEC_HI  = 16'hFFFD;
    localparam logic [15:0] ADR_PTR_LO  = 16'hFFFF;
    localparam logic [15:0] ADR_HI_WRAP = 16'hFF00;
    localparam logic [15:0] ADR_HI_OK   = 16'h0000;

endpackage

// File: rtl/cpu_probe_feeder.sv
module cpu_probe_feeder
    import cpu_probe_pkg::*;
#(
    parameter logic [15:0] ENTRY_ADDR  = 16'h1000,
    parameter logic [15:0] TARGET_ADDR = 16'h2000,
    parameter logic [7:0]  PROBE_ZP    = 8'h40
) (
    input  logic [15:0] addr,
    output logic [7:0]  data
);
    localparam logic [15:0] ENTRY_P1  = ENTRY_ADDR + 16'd1;
    localparam logic [15:0] ENTRY_P2  = ENTRY_ADDR + 16'd2;
    localparam logic [15:0] TARGET_P1 = TARGET_ADDR + 16'd1;

    always_comb begin
        if (addr == ADR_VEC_LO)                              data = ENTRY_ADDR[7:0];
        else if (addr == ADR_VEC_HI)                         data = ENTRY_ADDR[15:8];
        else if (addr == ENTRY_ADDR)                         data = OP_JMP_IND;
        else if (addr == ENTRY_P1 || addr == ENTRY_P2)       data = 8'hFF;
        else if (addr == ADR_PTR_LO)                         data = TARGET_ADDR[7:0];
        else if (addr == ADR_HI_WRAP || addr == ADR_HI_OK)   data = TARGET_ADDR[15:8];
        else if (addr == TARGET_ADDR)                        data = OP_SET_B0;
        else if (addr == TARGET_P1)                          data = PROBE_ZP;
        else                                                 data = OP_FILL;
    end

endmodule

// File: rtl/cpu_probe_timer.sv
module cpu_probe_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        if (clr)                    count_d = '0;
        else if (count_q != CNT_MAX) count_d = count_q + 1'b1;
        else                        count_d = count_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/cpu_variant_detect.sv
module cpu_variant_detect
    import cpu_probe_pkg::*;
#(
    parameter logic [15:0] ENTRY_ADDR  = 16'h1000,
    parameter logic [15:0] TARGET_ADDR = 16'h2000,
    parameter logic [7:0]  PROBE_ZP    = 8'h40,
    parameter int unsigned RST_CYC     = 4,
    parameter int unsigned PROBE_WIN   = 6,
    parameter int unsigned TIMEOUT_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw,
    output logic [7:0]  cpu_data_out,
    output logic        cpu_clk_en,
    output logic        cpu_rst_n,
    output logic [1:0]  variant,
    output logic        done,
    output logic        err
);
    localparam int unsigned MAX_A = (RST_CYC > PROBE_WIN) ? RST_CYC : PROBE_WIN;
    localparam int unsigned MAX_C = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
    localparam int unsigned CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(PROBE_WIN - 1);
    localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [15:0]      ZP_ADDR   = {8'h00, PROBE_ZP};

    typedef struct packed {
        probe_state_e state;
        logic [1:0]   variant;
        logic         done;
        logic         err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] count;
    logic             timed_out;

    cpu_probe_feeder #(
        .ENTRY_ADDR (ENTRY_ADDR),
        .TARGET_ADDR(TARGET_ADDR),
        .PROBE_ZP   (PROBE_ZP)
    ) feeder_i (
        .addr(cpu_addr),
        .data(cpu_data_out)
    );

    cpu_probe_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (seq_d.state != seq_q.state),
        .count(count)
    );

    assign timed_out = (count == TO_LAST);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_HOLD;
                    seq_d.err   = 1'b0;
                end
            end
            ST_HOLD: begin
                if (count == HOLD_LAST) seq_d.state = ST_VECTOR;
            end
            ST_VECTOR: begin
                if (cpu_rw && cpu_addr == ADR_VEC_LO) seq_d.state = ST_POINTER;
                else if (timed_out) begin
                    seq_d.state = ST_IDLE; seq_d.done = 1'b1; seq_d.err = 1'b1;
                end
            end
            ST_POINTER: begin
                if (cpu_rw && cpu_addr == ADR_PTR_LO) seq_d.state = ST_HIGH;
                else if (timed_out) begin
                    seq_d.state = ST_IDLE; seq_d.done = 1'b1; seq_d.err = 1'b1;
                end
            end
            ST_HIGH: begin
                if (cpu_rw && cpu_addr == ADR_HI_WRAP) begin
                    seq_d.state = ST_IDLE; seq_d.done = 1'b1; seq_d.variant = VAR_NMOS;
                end else if (cpu_rw && cpu_addr == ADR_HI_OK) begin
                    if (count == '0) begin
                        seq_d.state = ST_IDLE; seq_d.done = 1'b1; seq_d.variant = VAR_WIDE;
                    end else begin
                        seq_d.state = ST_FETCH;
                    end
                end else if (timed_out) begin
                    seq_d.state = ST_IDLE; seq_d.done = 1'b1; seq_d.err = 1'b1;
                end
            end
            ST_FETCH: begin
                if (cpu_rw && cpu_addr == TARGET_ADDR) seq_d.state = ST_PROBE;
                else if (timed_out) begin
                    seq_d.state = ST_IDLE; seq_d.done = 1'b1; seq_d.err = 1'b1;
                end
            end
            ST_PROBE: begin
                if (cpu_rw && cpu_addr == ZP_ADDR) begin
                    seq_d.state = ST_IDLE; seq_d.done = 1'b1; seq_d.variant = VAR_CMOS_BIT;
                end else if (count == WIN_LAST) begin
                    seq_d.state = ST_IDLE; seq_d.done = 1'b1; seq_d.variant = VAR_CMOS_NOBIT;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, variant: 2'd0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cpu_clk_en = (seq_q.state != ST_IDLE);
    assign cpu_rst_n  = (seq_q.state != ST_IDLE) && (seq_q.state != ST_HOLD);
    assign variant    = seq_q.variant;
    assign done       = seq_q.done;
    assign err        = seq_q.err;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_CPU_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cpu_rst_n && !cpu_clk_en)); // R8
    AST_VARIANT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(variant) |-> (done && !err)); // R9
    AST_ERR_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done); // R9
    AST_WRAP_MEANS_NMOS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && variant == VAR_NMOS) |-> ($past(cpu_addr) == ADR_HI_WRAP && $past(cpu_rw))); // R4
    AST_WIDE_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && variant == VAR_WIDE) |-> ($past(cpu_addr) == ADR_HI_OK && $past(cpu_addr, 2) == ADR_PTR_LO)); // R5
    AST_BIT_ON_ZP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && variant == VAR_CMOS_BIT) |-> ($past(cpu_addr) == ZP_ADDR && $past(cpu_rw))); // R6

endmodule

// File: tb/cpu_variant_detect_tb.sv
module cpu_variant_detect_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam int K_NMOS = 0, K_WIDE = 1, K_BIT = 2, K_NOBIT = 3,
                   K_LATE = 4, K_ZPWR = 5, K_TO_HIGH = 6, K_TO_VEC = 7;

    localparam int NVEC = 9;
    localparam logic [6:0] VEC [NVEC] = '{
        {4'(K_NOBIT),   1'b0, 2'd2},
        {4'(K_TO_HIGH), 1'b1, 2'd2},
        {4'(K_NMOS),    1'b0, 2'd0},
        {4'(K_WIDE),    1'b0, 2'd3},
        {4'(K_TO_VEC),  1'b1, 2'd3},
        {4'(K_BIT),     1'b0, 2'd1},
        {4'(K_LATE),    1'b0, 2'd1},
        {4'(K_ZPWR),    1'b0, 2'd2},
        {4'(K_NMOS),    1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cpu_addr = 16'h01FF;
    logic        cpu_rw = 1'b1;
    logic [7:0]  cpu_data_out;
    logic        cpu_clk_en, cpu_rst_n, done, err;
    logic [1:0]  variant;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cpu_variant_detect dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_data_out(cpu_data_out),
        .cpu_clk_en(cpu_clk_en), .cpu_rst_n(cpu_rst_n),
        .variant(variant), .done(done), .err(err)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic rw, input bit chk, input logic [7:0] exp);
        cpu_addr = a;
        cpu_rw = rw;
        #1;
        if (chk) check("R3 data", {8'h00, cpu_data_out}, {8'h00, exp});
        @(negedge clk);
    endtask

    task automatic idle_steps(input int n);
        for (int i = 0; i < n; i++) step(16'h01FF - 16'(i), 1'b1, 1'b0, 8'h00);
    endtask

    task automatic launch();
        int hold;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 err cleared", {15'd0, err}, 16'd0);
        hold = 0;
        while (!cpu_rst_n && hold < 50) begin
            if (cpu_clk_en) hold++;
            @(negedge clk);
        end
        check("R2 hold cycles", 16'(hold), 16'd4);
        check("R2 clock on after release", {15'd0, cpu_clk_en}, 16'd1);
    endtask

    task automatic run_prefix();
        step(16'h01FF, 1'b1, 1'b1, 8'hEA);
        step(16'h01FE, 1'b1, 1'b0, 8'h00);
        step(16'hFFFC, 1'b1, 1'b1, 8'h00);
        step(16'hFFFD, 1'b1, 1'b1, 8'h10);
        step(16'h1000, 1'b1, 1'b1, 8'h6C);
        step(16'h1001, 1'b1, 1'b1, 8'hFF);
        step(16'h1002, 1'b1, 1'b1, 8'hFF);
        step(16'hFFFF, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic run_cmos8_head();
        step(16'h1002, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 1'b1, 1'b1, 8'h20);
        step(16'h2000, 1'b1, 1'b1, 8'h87);
        step(16'h2001, 1'b1, 1'b1, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 clk_en", {15'd0, cpu_clk_en}, 16'd0);
        check("R1 cpu_rst_n", {15'd0, cpu_rst_n}, 16'd0);
        check("R1 done", {15'd0, done}, 16'd0);
        check("R1 err", {15'd0, err}, 16'd0);
        check("R1 variant", {14'd0, variant}, 16'd0);

        for (int v = 0; v < NVEC; v++) begin
            int kind;
            kind = int'(VEC[v][6:3]);
            launch();
            case (kind)
                K_NMOS: begin run_prefix(); step(16'hFF00, 1'b1, 1'b1, 8'h20); end
                K_WIDE: begin run_prefix(); step(16'h0000, 1'b1, 1'b1, 8'h20); end
                K_BIT:  begin run_prefix(); run_cmos8_head(); step(16'h0040, 1'b1, 1'b0, 8'h00); end
                K_NOBIT: begin run_prefix(); run_cmos8_head(); idle_steps(5); end
                K_LATE: begin run_prefix(); run_cmos8_head(); idle_steps(4); step(16'h0040, 1'b1, 1'b0, 8'h00); end
                K_ZPWR: begin run_prefix(); run_cmos8_head(); step(16'h0040, 1'b0, 1'b0, 8'h00); idle_steps(4); end
                K_TO_HIGH: begin run_prefix(); idle_steps(16); end
                default: idle_steps(16);
            endcase
            check($sformatf("R4 R5 R6 R7 R9 done vec %0d", v), {15'd0, done}, 16'd1);
            check($sformatf("R4 R5 R6 R7 R9 variant vec %0d", v), {14'd0, variant}, {14'd0, VEC[v][1:0]});
            check($sformatf("R9 err vec %0d", v), {15'd0, err}, {15'd0, VEC[v][2]});
            check("R8 cpu reset back low", {15'd0, cpu_rst_n}, 16'd0);
            @(negedge clk);
            check("R8 done one cycle", {15'd0, done}, 16'd0);
            check("R8 clock stopped", {15'd0, cpu_clk_en}, 16'd0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule